// File: doc/BRIEF.md
# Reshapeable LUT-Cell Memory

This block is a small memory built from eight 16-entry, 1-bit storage cells. A 3-bit shape code regroups these cells into one of seven depth-by-width layouts. There are four shared-address layouts and three layouts with separate read and write addresses. The ports are sized for the widest and deepest case: an 8-bit data path and a 7-bit address.

In a shared-address layout, the write address also picks the word that is read, and the read-address input is ignored. In a separate-address layout, each logical bit is kept in two cells that are always written together. The second copy answers the read address, so a read and a write can use different words in the same cycle. This halves the capacity.

Writes take effect on the rising clock edge. Reads are combinational. The layout is chosen by a shape decoder, a write-steering stage and a read multiplexer. No state machine is needed: the only sequential elements are the cells themselves.

Top module: `lut_ram_shaper`

## Requirements
- R1: Shape codes 0, 1, 2 and 3 select shared-address layouts of 16x8, 32x4, 64x2 and 128x1. Every word of the selected depth is stored independently. The word index is the address modulo the depth.
- R2: Shape codes 4, 5 and 6 select separate-address layouts of 16x4, 32x2 and 64x1. Every word of the selected depth is stored independently.
- R3: A write happens only on a rising clock edge while `wr_en` is 1. With `wr_en` at 0, stored words keep their values.
- R4: `rd_data` follows address changes combinationally, without waiting for a clock edge.
- R5: In shared-address layouts, `rd_data` shows the word at `wr_addr`, and `rd_addr` has no effect.
- R6: In separate-address layouts, `rd_data` shows the word at `rd_addr` while a write to `wr_addr` proceeds in the same cycle.
- R7: A read of the word being written in the current cycle shows the old contents until the clock edge that completes the write.
- R8: Data bits at or above the layout's width read as 0. Address bits at or above the layout's depth are ignored.
- R9: Shape code 7 is inert: `rd_data` is 0, and writes change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| shape_sel | input | 3 | Layout code (0..6 as in R1/R2, 7 inert) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write address; also the read address in shared layouts |
| wr_data | input | 8 | Write data, low bits used by narrow layouts |
| rd_addr | input | 7 | Read address for separate-address layouts |
| rd_data | output | 8 | Combinational read data, upper bits zero when narrow |

## Verification
The embedded assertions check on every clock the bookkeeping that can be seen within one cycle. A write strobe enables exactly as many cells as the layout is wide, or twice that many for paired layouts, with both copies matched. Nothing is enabled without the strobe or in the inert code. Unused read bits stay zero. The bench's behavioural word-array model is needed for everything that spans cycles: correct address-to-cell mapping across depths, independence of stored words, read-before-write behaviour on a colliding address, and data surviving a stretch in the inert code.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int CELL_AW  = 4;
    localparam int NUM_CELL = 8;
    localparam int DATA_W   = 8;
    localparam int GRP_W    = 3;
    localparam int ADDR_W   = CELL_AW + GRP_W;
    localparam int SHAPE_W  = 3;

    typedef enum logic [SHAPE_W-1:0] {
        SHP_S16X8  = 3'd0,
        SHP_S32X4  = 3'd1,
        SHP_S64X2  = 3'd2,
        SHP_S128X1 = 3'd3,
        SHP_D16X4  = 3'd4,
        SHP_D32X2  = 3'd5,
        SHP_D64X1  = 3'd6,
        SHP_NONE   = 3'd7
    } shape_e;

    function automatic logic shape_dual(input shape_e s);
        return (s == SHP_D16X4) || (s == SHP_D32X2) || (s == SHP_D64X1);
    endfunction

    function automatic logic shape_live(input shape_e s);
        return s != SHP_NONE;
    endfunction

    // number of upper address bits used to pick a cell group
    function automatic logic [1:0] shape_grp_bits(input shape_e s);
        logic [1:0] k;
        unique case (s)
            SHP_S16X8, SHP_D16X4:  k = 2'd0;
            SHP_S32X4, SHP_D32X2:  k = 2'd1;
            SHP_S64X2, SHP_D64X1:  k = 2'd2;
            SHP_S128X1:            k = 2'd3;
            default:               k = 2'd0;
        endcase
        return k;
    endfunction

    // log2 of the logical word width
    function automatic logic [1:0] shape_log_w(input shape_e s);
        logic [1:0] lw;
        unique case (s)
            SHP_S16X8:             lw = 2'd3;
            SHP_S32X4, SHP_D16X4:  lw = 2'd2;
            SHP_S64X2, SHP_D32X2:  lw = 2'd1;
            default:               lw = 2'd0;
        endcase
        return lw;
    endfunction

endpackage

// File: rtl/lrs_cell.sv
module lrs_cell #(
    parameter int AW = lrs_pkg::CELL_AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          din,
    input  logic [AW-1:0] raddr,
    output logic          dout
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (we) begin
            bits_q[waddr] <= din;
        end
    end

    assign dout = bits_q[raddr];

endmodule

// File: rtl/lrs_wr_steer.sv
module lrs_wr_steer
    import lrs_pkg::*;
#(
    parameter int NCELL = NUM_CELL,
    parameter int DW    = DATA_W,
    parameter int GW    = GRP_W
) (
    input  logic             clk,
    input  shape_e           shape,
    input  logic             wr_en,
    input  logic [GW-1:0]    wr_grp,
    input  logic [DW-1:0]    wr_data,
    output logic [NCELL-1:0] cell_we,
    output logic [NCELL-1:0] cell_din
);
    localparam int HALF = NCELL / 2;

    logic [1:0]    k;
    logic [1:0]    lw;
    logic          dual;
    logic          live;
    logic [GW-1:0] grp;
    logic [GW-1:0] lmask;

    always_comb begin
        k     = shape_grp_bits(shape);
        lw    = shape_log_w(shape);
        dual  = shape_dual(shape);
        live  = shape_live(shape);
        grp   = wr_grp & ~({GW{1'b1}} << k);
        lmask = ~({GW{1'b1}} << lw);
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        localparam logic [GW-1:0] CIDX = GW'(c);
        localparam logic [GW-1:0] PIDX = GW'(c % HALF);
        logic [GW-1:0] idx;
        logic          we_l;
        logic          din_l;

        always_comb begin
            idx   = dual ? PIDX : CIDX;
            we_l  = 1'b0;
            din_l = 1'b0;
            if (live && ((idx >> lw) == grp)) begin
                we_l  = wr_en;
                din_l = wr_data[idx & lmask];
            end
        end

        assign cell_we[c]  = we_l;
        assign cell_din[c] = din_l;
    end

    always_ff @(posedge clk) begin
        if (!$isunknown({shape, wr_en, wr_grp})) begin
            p_idle_no_write_r3 : assert (wr_en || cell_we == '0)
                else $error("cell enabled without write strobe");
            p_inert_no_write_r9 : assert (live || cell_we == '0)
                else $error("cell enabled in inert shape");
            p_width_enables_r1 : assert (!(wr_en && live && !dual) ||
                                         ($countones(cell_we) == (1 << lw)))
                else $error("shared layout enabled wrong cell count");
            p_pair_enables_r6 : assert (!(wr_en && dual) ||
                                        ((cell_we[HALF-1:0] == cell_we[NCELL-1:HALF]) &&
                                         ($countones(cell_we) == (2 << lw))))
                else $error("paired copies not written together");
        end
    end

endmodule

// File: rtl/lrs_rd_mux.sv
module lrs_rd_mux
    import lrs_pkg::*;
#(
    parameter int NCELL = NUM_CELL,
    parameter int DW    = DATA_W,
    parameter int GW    = GRP_W
) (
    input  logic             clk,
    input  shape_e           shape,
    input  logic [GW-1:0]    wr_grp,
    input  logic [GW-1:0]    rd_grp,
    input  logic [NCELL-1:0] cell_q,
    output logic [DW-1:0]    rd_data
);
    localparam int HALF = NCELL / 2;

    logic [1:0]    k;
    logic [1:0]    lw;
    logic          dual;
    logic          live;
    logic [GW-1:0] grp;

    always_comb begin
        k    = shape_grp_bits(shape);
        lw   = shape_log_w(shape);
        dual = shape_dual(shape);
        live = shape_live(shape);
        grp  = (dual ? rd_grp : wr_grp) & ~({GW{1'b1}} << k);
    end

    for (genvar b = 0; b < DW; b++) begin : g_bit
        localparam logic [GW-1:0] BIDX = GW'(b);
        localparam logic [GW:0]   BW   = (GW+1)'(b);
        logic [GW-1:0] src;
        logic          bit_l;

        always_comb begin
            src   = (grp << lw) | BIDX;
            bit_l = 1'b0;
            if (dual) begin
                src = src | GW'(HALF);
            end
            if (live && ((BW >> lw) == '0)) begin
                bit_l = cell_q[src];
            end
        end

        assign rd_data[b] = bit_l;
    end

    always_ff @(posedge clk) begin
        if (!$isunknown({shape, wr_grp, rd_grp, cell_q})) begin
            p_narrow_zero_r8 : assert ((rd_data >> (1 << lw)) == '0 || !live || lw == 2'd3)
                else $error("unused read bits not zero");
            p_inert_read_r9 : assert (live || rd_data == '0)
                else $error("inert shape reads nonzero");
        end
    end

endmodule

// File: rtl/lut_ram_shaper.sv
module lut_ram_shaper
    import lrs_pkg::*;
#(
    parameter int CAW   = CELL_AW,
    parameter int NCELL = NUM_CELL,
    parameter int DW    = DATA_W,
    parameter int GW    = GRP_W,
    parameter int SW    = SHAPE_W
) (
    input  logic               clk,
    input  logic [SW-1:0]      shape_sel,
    input  logic               wr_en,
    input  logic [CAW+GW-1:0]  wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [CAW+GW-1:0]  rd_addr,
    output logic [DW-1:0]      rd_data
);
    localparam int AW   = CAW + GW;
    localparam int HALF = NCELL / 2;

    shape_e           shape;
    logic             dual;
    logic [NCELL-1:0] cell_we;
    logic [NCELL-1:0] cell_din;
    logic [NCELL-1:0] cell_q;

    assign shape = shape_e'(shape_sel);
    assign dual  = shape_dual(shape);

    lrs_wr_steer #(.NCELL(NCELL), .DW(DW), .GW(GW)) u_steer (
        .clk      (clk),
        .shape    (shape),
        .wr_en    (wr_en),
        .wr_grp   (wr_addr[AW-1:CAW]),
        .wr_data  (wr_data),
        .cell_we  (cell_we),
        .cell_din (cell_din)
    );

    for (genvar c = 0; c < NCELL; c++) begin : g_store
        logic [CAW-1:0] ra;
        if (c >= HALF) begin : g_copy
            assign ra = dual ? rd_addr[CAW-1:0] : wr_addr[CAW-1:0];
        end else begin : g_prim
            assign ra = wr_addr[CAW-1:0];
        end

        lrs_cell #(.AW(CAW)) u_cell (
            .clk   (clk),
            .we    (cell_we[c]),
            .waddr (wr_addr[CAW-1:0]),
            .din   (cell_din[c]),
            .raddr (ra),
            .dout  (cell_q[c])
        );
    end

    lrs_rd_mux #(.NCELL(NCELL), .DW(DW), .GW(GW)) u_mux (
        .clk     (clk),
        .shape   (shape),
        .wr_grp  (wr_addr[AW-1:CAW]),
        .rd_grp  (rd_addr[AW-1:CAW]),
        .cell_q  (cell_q),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sim_lut_ram_shaper.sv
`timescale 1ns/1ps
module sim_lut_ram_shaper;

    logic       clk = 1'b0;
    logic [2:0] shape_sel = 3'd7;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int unsigned lcg = 32'h1234_5678;

    logic [7:0] model [0:127];

    always #2.5 clk = ~clk;

    lut_ram_shaper u0 (
        .clk       (clk),
        .shape_sel (shape_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    function automatic int depth_of(input logic [2:0] m);
        case (m)
            3'd0, 3'd4: return 16;
            3'd1, 3'd5: return 32;
            3'd2, 3'd6: return 64;
            3'd3:       return 128;
            default:    return 1;
        endcase
    endfunction

    function automatic logic [7:0] mask_of(input logic [2:0] m);
        case (m)
            3'd0:       return 8'hFF;
            3'd1, 3'd4: return 8'h0F;
            3'd2, 3'd5: return 8'h03;
            3'd3, 3'd6: return 8'h01;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] expect_rd(input logic [6:0] wa, input logic [6:0] ra);
        logic [6:0] a;
        if (shape_sel == 3'd7) return 8'h00;
        a = (shape_sel >= 3'd4) ? ra : wa;
        return model[int'(a) % depth_of(shape_sel)] & mask_of(shape_sel);
    endfunction

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg >> 8;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s shape=%0d actual=%h expected=%h", tag, shape_sel, act, exp);
        end
    endtask

    // drive one cycle, compare the combinational read before the edge, then commit
    task automatic step(input logic we, input logic [6:0] wa, input logic [7:0] wd,
                        input logic [6:0] ra, input string tag, input bit cmp);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        #1;
        if (cmp) check(tag, rd_data, expect_rd(wa, ra));
        @(posedge clk);
        if (we && shape_sel != 3'd7)
            model[int'(wa) % depth_of(shape_sel)] = wd & mask_of(shape_sel);
    endtask

    task automatic set_shape(input logic [2:0] m);
        @(negedge clk);
        wr_en = 1'b0;
        shape_sel = m;
    endtask

    task automatic fill(input logic [2:0] m);
        set_shape(m);
        for (int a = 0; a < depth_of(m); a++)
            step(1'b1, 7'(a), 8'(a * 37 + 11 + m), 7'd0, "fill", 1'b0);
    endtask

    initial begin
        // reset state: inert shape reads zero
        #1;
        check("R9", rd_data, 8'h00);

        for (int m = 0; m < 7; m++) begin
            fill(3'(m));
            // readback of every word
            for (int a = 0; a < depth_of(3'(m)); a++)
                step(1'b0, 7'(a), 8'h00, 7'(a), (m < 4) ? "R1" : "R2", 1'b1);
            // mixed traffic, full address range
            for (int i = 0; i < 60; i++) begin
                int unsigned r = rnd();
                step(r[0], 7'(r >> 1), 8'(r >> 8), 7'(r >> 16), (m < 4) ? "R5" : "R6", 1'b1);
            end
        end

        // R3: strobe low leaves contents alone
        fill(3'd0);
        step(1'b0, 7'd9, 8'hA5, 7'd0, "R3", 1'b1);
        step(1'b0, 7'd9, 8'h00, 7'd0, "R3", 1'b1);
        check("R3", rd_data, (8'(9 * 37 + 11)));

        // R5: read address has no effect in shared layouts
        step(1'b0, 7'd3, 8'h00, 7'd12, "R5", 1'b1);
        check("R5", rd_data, 8'(3 * 37 + 11));

        // R8: upper address bits ignored at depth 16
        step(1'b1, 7'h75, 8'h3C, 7'd0, "R8", 1'b1);
        step(1'b0, 7'h05, 8'h00, 7'd0, "R8", 1'b1);
        check("R8", rd_data, 8'h3C);

        // R8: narrow width masks upper data bits
        fill(3'd3);
        step(1'b1, 7'd100, 8'hFE, 7'd0, "R8", 1'b1);
        step(1'b0, 7'd100, 8'h00, 7'd0, "R8", 1'b1);
        check("R8", rd_data, 8'h00);

        // R7 + R6: collision in a paired layout
        fill(3'd4);
        step(1'b1, 7'd6, 8'h0A, 7'd6, "R7", 1'b1);
        check("R7", rd_data, 8'(6 * 37 + 11 + 4) & 8'h0F);
        step(1'b0, 7'd1, 8'h00, 7'd6, "R7", 1'b1);
        check("R7", rd_data, 8'h0A);

        // R4: combinational address follow, no clock edge
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = 7'd2; #0.5;
        check("R4", rd_data, model[2] & 8'h0F);
        rd_addr = 7'd6; #0.5;
        check("R4", rd_data, 8'h0A);

        // R9: inert code ignores writes and reads zero
        set_shape(3'd7);
        step(1'b1, 7'd6, 8'h05, 7'd6, "R9", 1'b1);
        check("R9", rd_data, 8'h00);
        set_shape(3'd4);
        step(1'b0, 7'd0, 8'h00, 7'd6, "R9", 1'b1);
        check("R9", rd_data, 8'h0A);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule